// File: doc/BRIEF.md
# Privileged Address-Space Move Unit

This unit carries out one privileged transfer of a byte, word or long value between a general register and memory. A controller presents a 16-bit opcode, a 16-bit extension word, the current supervisor flag and an effective address that has already been computed, and pulses `start`. The unit checks privilege and the encoding, then issues a single read or write on a request/acknowledge memory bus. A read result is then written back into the register file.

The register file lives outside the unit. The unit drives a read-select to fetch the source register for a write, or the old contents of the destination for a load. It drives a one-cycle write port when a load completes. A byte or word load keeps the upper bits of a data register and sign-extends into an address register. A finished instruction raises `done` for one cycle, together with a status (privilege trap, bad size, bad addressing mode, or a normal transfer that reports its base cycle cost). The unit has no condition-code port, so it cannot change the flags.

Top module: `asmove_unit`

## Requirements
- R1: When `start` is accepted with `supervisor` low, no bus request is made and no register is written. In the next cycle `done`=1, `trap_priv`=1 and `trap_vector`=8.
- R2: Opcode bits 7:6 give the size: 00 byte, 01 word, 10 long, driven on `mem_size` as the same code. With privilege present, code 11 gives `done` with `bad_size`=1 in the next cycle, and no bus request.
- R3: Opcode bits 5:3 (mode) and 2:0 (register) must name a memory mode: modes 2 to 6 with any register, or mode 7 with register 0 or 1. Any other pair gives `done` with `bad_ea`=1 in the next cycle and no bus request.
- R4: Extension bits 15:12 pick the register index 0 to 15. Indices 0 to 7 are data registers and 8 to 15 are address registers. That index appears on `rf_rd_sel` and `rf_wr_sel`.
- R5: Extension bit 11 set means a memory write (`mem_we`=1). Clear means a memory read. `mem_addr` carries the effective address latched at `start`.
- R6: A byte or word load into a data register replaces only its low 8 or 16 bits. A long load replaces all 32 bits.
- R7: A byte or word load into an address register is sign-extended to 32 bits.
- R8: A write drives the low 8, 16 or 32 bits of the selected register on `mem_wdata`, with the unused upper bits zero. The register is left unchanged.
- R9: `mem_req` stays high with a stable address until `mem_ack`. `done` follows one cycle after the acknowledge, with the register write in that cycle for a load, and `cycles`=4. A trap or invalid encoding reports `cycles`=0.
- R10: A `start` is accepted only while idle. A `start` during a transfer or during the `done` cycle has no effect, so the cycle after `done` shows `done`=0, `mem_req`=0 and `busy`=0.
- R11: Checks apply in priority order: privilege first, then size, then addressing mode. Only the highest-priority status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken only while idle) |
| opcode | input | 16 | Instruction opcode word |
| ext_word | input | 16 | Extension word |
| supervisor | input | 1 | Supervisor flag at start |
| ea_addr | input | 32 | Precomputed effective address |
| rf_rd_sel | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_wr_sel | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| trap_priv | output | 1 | Privilege violation status (valid with done) |
| trap_vector | output | 8 | Exception vector number (valid with done) |
| bad_size | output | 1 | Invalid size status (valid with done) |
| bad_ea | output | 1 | Invalid addressing mode status (valid with done) |
| cycles | output | 4 | Base cycle cost of a completed transfer (valid with done) |

## Verification
Two collisions are provoked on purpose. The first is a new `start` arriving in the very `done` cycle of the previous instruction. The second is several faults in one encoding: a user-mode opcode with the reserved size, and a reserved size together with a register-direct mode. For the first, the bench holds `start` high across the `done` edge and judges that the following cycle shows no request, no `done` and not busy. For the second, it judges that exactly the highest-priority status flag rises and the bus stays quiet. Acknowledges come at latencies from zero upward, so the request-hold and write-back timing is also seen with an acknowledge in the first request cycle.

// File: rtl/asmove_pkg.sv
package asmove_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned SIZE_LSB = 6;
  localparam int unsigned MODE_LSB = 3;
  localparam int unsigned EREG_LSB = 0;
  localparam int unsigned SEL_LSB  = 12;
  localparam int unsigned DIR_BIT  = 11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_XFER = 2'b01,
    ST_DONE = 2'b10
  } state_e;

  typedef struct packed {
    size_e            size;
    logic [SEL_W-1:0] reg_sel;
    logic             to_mem;
  } instr_t;

  // memory-type addressing modes only
  function automatic logic ea_is_memory(input logic [2:0] mode, input logic [2:0] ereg);
    case (mode)
      3'd2, 3'd3, 3'd4, 3'd5, 3'd6: ea_is_memory = 1'b1;
      3'd7:                         ea_is_memory = (ereg <= 3'd1);
      default:                      ea_is_memory = 1'b0;
    endcase
  endfunction

  function automatic int unsigned size_bytes(input size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = 1;
      SZ_WORD: size_bytes = 2;
      default: size_bytes = DATA_W / 8;
    endcase
  endfunction

endpackage

// File: rtl/asmove_decode.sv
module asmove_decode
  import asmove_pkg::*;
(
  input  logic [WORD_W-1:0] opcode,
  input  logic [WORD_W-1:0] ext_word,
  output instr_t            instr,
  output logic              size_bad,
  output logic              ea_bad
);

  logic [1:0] size_code;
  logic [2:0] ea_mode;
  logic [2:0] ea_reg;

  assign size_code = opcode[SIZE_LSB +: 2];
  assign ea_mode   = opcode[MODE_LSB +: 3];
  assign ea_reg    = opcode[EREG_LSB +: 3];

  assign instr.size    = size_e'(size_code);
  assign instr.reg_sel = ext_word[SEL_LSB +: SEL_W];
  assign instr.to_mem  = ext_word[DIR_BIT];

  assign size_bad = (size_code == SZ_BAD);
  assign ea_bad   = !ea_is_memory(ea_mode, ea_reg);

endmodule

// File: rtl/asmove_lanes.sv
module asmove_lanes
  import asmove_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  size_e         size,
  input  logic          is_areg,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] store_src,
  output logic [DW-1:0] reg_val,
  output logic [DW-1:0] store_val
);

  localparam int unsigned NLANE = DW / 8;

  int unsigned nbytes;
  logic        sign_bit;

  assign nbytes = size_bytes(size);

  always_comb begin
    case (size)
      SZ_BYTE: sign_bit = load_val[7];
      SZ_WORD: sign_bit = load_val[15];
      default: sign_bit = load_val[DW-1];
    endcase
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic live;
    assign live = (i < nbytes);
    assign store_val[8*i +: 8] = live ? store_src[8*i +: 8] : 8'h00;
    assign reg_val[8*i +: 8]   = live    ? load_val[8*i +: 8] :
                                 is_areg ? {8{sign_bit}}      : old_val[8*i +: 8];
  end

endmodule

// File: rtl/asmove_ctrl.sv
module asmove_ctrl
  import asmove_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   supervisor,
  input  logic   size_bad,
  input  logic   ea_bad,
  input  logic   mem_ack,
  output state_e state,
  output logic   accept,
  output logic   capture,
  output logic   done,
  output logic   trap_priv,
  output logic   bad_size,
  output logic   bad_ea,
  output logic   xfer_ok
);

  logic priv_q, size_q, ea_q, ok_q;
  logic go_xfer;

  assign accept  = start && (state == ST_IDLE);
  assign capture = (state == ST_XFER) && mem_ack;
  assign go_xfer = supervisor && !size_bad && !ea_bad;
  assign done    = (state == ST_DONE);

  assign trap_priv = done && priv_q;
  assign bad_size  = done && size_q;
  assign bad_ea    = done && ea_q;
  assign xfer_ok   = done && ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      priv_q <= 1'b0;
      size_q <= 1'b0;
      ea_q   <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          priv_q <= !supervisor;
          size_q <= supervisor && size_bad;
          ea_q   <= supervisor && !size_bad && ea_bad;
          ok_q   <= 1'b0;
          state  <= go_xfer ? ST_XFER : ST_DONE;
        end
        ST_XFER: if (mem_ack) begin
          ok_q  <= 1'b1;
          state <= ST_DONE;
        end
        default: begin
          priv_q <= 1'b0;
          size_q <= 1'b0;
          ea_q   <= 1'b0;
          ok_q   <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == ST_IDLE));

  // R11
  one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_priv, bad_size, bad_ea, xfer_ok}));

  // R9
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (done && xfer_ok));

endmodule

// File: rtl/asmove_unit.sv
module asmove_unit
  import asmove_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned PRIV_VEC  = 8,
  parameter int unsigned COST_W    = 4,
  parameter int unsigned BASE_COST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] opcode,
  input  logic [WORD_W-1:0] ext_word,
  input  logic              supervisor,
  input  logic [DATA_W-1:0] ea_addr,
  output logic [SEL_W-1:0]  rf_rd_sel,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [SEL_W-1:0]  rf_wr_sel,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              trap_priv,
  output logic [VEC_W-1:0]  trap_vector,
  output logic              bad_size,
  output logic              bad_ea,
  output logic [COST_W-1:0] cycles
);

  instr_t            in_dec, cur;
  logic              in_size_bad, in_ea_bad;
  state_e            state;
  logic              accept, capture, xfer_ok;
  logic [DATA_W-1:0] ea_q, load_q, old_q;
  logic [DATA_W-1:0] reg_val, store_val;

  asmove_decode u_dec (
    .opcode   (opcode),
    .ext_word (ext_word),
    .instr    (in_dec),
    .size_bad (in_size_bad),
    .ea_bad   (in_ea_bad)
  );

  asmove_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .supervisor (supervisor),
    .size_bad   (in_size_bad),
    .ea_bad     (in_ea_bad),
    .mem_ack    (mem_ack),
    .state      (state),
    .accept     (accept),
    .capture    (capture),
    .done       (done),
    .trap_priv  (trap_priv),
    .bad_size   (bad_size),
    .bad_ea     (bad_ea),
    .xfer_ok    (xfer_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      ea_q   <= '0;
      load_q <= '0;
      old_q  <= '0;
    end else begin
      if (accept) begin
        cur  <= in_dec;
        ea_q <= ea_addr;
      end
      if (capture) begin
        load_q <= mem_rdata;
        old_q  <= rf_rd_data;
      end
    end
  end

  asmove_lanes #(.DW(DATA_W)) u_lanes (
    .size      (cur.size),
    .is_areg   (cur.reg_sel[SEL_W-1]),
    .old_val   (old_q),
    .load_val  (load_q),
    .store_src (rf_rd_data),
    .reg_val   (reg_val),
    .store_val (store_val)
  );

  assign busy        = (state != ST_IDLE);
  assign mem_req     = (state == ST_XFER);
  assign mem_we      = mem_req && cur.to_mem;
  assign mem_addr    = ea_q;
  assign mem_size    = cur.size;
  assign mem_wdata   = mem_req ? store_val : '0;
  assign rf_rd_sel   = cur.reg_sel;
  assign rf_wr_sel   = cur.reg_sel;
  assign rf_we       = xfer_ok && !cur.to_mem;
  assign rf_wr_data  = reg_val;
  assign trap_vector = trap_priv ? VEC_W'(PRIV_VEC) : '0;
  assign cycles      = xfer_ok ? COST_W'(BASE_COST) : '0;

  // R1
  priv_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !supervisor) |=> (trap_priv && trap_vector == VEC_W'(PRIV_VEC) && !mem_req && !rf_we));

  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && supervisor && opcode[SIZE_LSB +: 2] == 2'b11) |=> (bad_size && !mem_req));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7
  areg_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wr_sel[SEL_W-1] && cur.size == SZ_BYTE) |-> (rf_wr_data[DATA_W-1:8] == {(DATA_W-8){rf_wr_data[7]}}));

  // R10
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mem_req && !done));

endmodule

// File: tb/tb_asmove_unit.sv
`timescale 1ns/1ps
module tb_asmove_unit;
  import asmove_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] opcode, ext_word;
  logic        supervisor;
  logic [31:0] ea_addr;
  logic [3:0]  rf_rd_sel, rf_wr_sel;
  logic [31:0] rf_rd_data, rf_wr_data;
  logic        rf_we;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        busy, done, trap_priv, bad_size, bad_ea;
  logic [7:0]  trap_vector;
  logic [3:0]  cycles;

  always #4 clk = ~clk;

  asmove_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .ext_word(ext_word),
    .supervisor(supervisor), .ea_addr(ea_addr), .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done), .trap_priv(trap_priv),
    .trap_vector(trap_vector), .bad_size(bad_size), .bad_ea(bad_ea), .cycles(cycles)
  );

  logic [31:0] rf [16];
  logic [31:0] model [16];
  assign rf_rd_data = rf[rf_rd_sel];
  always @(posedge clk) if (rf_we) rf[rf_wr_sel] <= rf_wr_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_load(input logic [31:0] old, input logic [31:0] m,
                                           input logic [1:0] sz, input bit areg);
    if (sz == 2'd0) return areg ? {{24{m[7]}}, m[7:0]} : {old[31:8], m[7:0]};
    if (sz == 2'd1) return areg ? {{16{m[15]}}, m[15:0]} : {old[31:16], m[15:0]};
    return m;
  endfunction

  function automatic logic [31:0] ref_store(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 2'd0) return v & 32'h0000_00FF;
    if (sz == 2'd1) return v & 32'h0000_FFFF;
    return v;
  endfunction

  function automatic bit ref_mode_ok(input logic [2:0] md, input logic [2:0] er);
    return (md >= 3'd2 && md <= 3'd6) || (md == 3'd7 && er < 3'd2);
  endfunction

  task automatic run(input logic [1:0] sz, input logic [2:0] md, input logic [2:0] er,
                     input logic [3:0] sel, input bit dir, input bit sup, input logic [31:0] ea,
                     input logic [31:0] rdval, input int lat, input bit poke);
    bit e_priv, e_size, e_ea, go;
    logic [31:0] exp_v;
    e_priv = !sup;
    e_size = sup && (sz == 2'b11);
    e_ea   = sup && (sz != 2'b11) && !ref_mode_ok(md, er);
    go     = !(e_priv || e_size || e_ea);
    @(negedge clk);
    opcode = {8'h0E, sz, md, er};
    ext_word = {sel, dir, 11'h000};
    supervisor = sup;
    ea_addr = ea;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opcode = 16'hFFFF;
    ea_addr = ~ea;
    if (go) begin
      for (int k = 0; k <= lat; k++) begin
        chk("R9 request held", {31'd0, mem_req}, 32'd1);
        chk("R9 no early done", {31'd0, done}, 32'd0);
        chk("R5 address", mem_addr, ea);
        chk("R5 direction", {31'd0, mem_we}, {31'd0, dir});
        chk("R2 size code", {30'd0, mem_size}, {30'd0, sz});
        chk("R4 read select", {28'd0, rf_rd_sel}, {28'd0, sel});
        if (dir) chk("R8 write data", mem_wdata, ref_store(model[sel], sz));
        if (k == lat) begin
          mem_ack = 1'b1;
          mem_rdata = rdval;
        end
        @(negedge clk);
        mem_ack = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
      end
      chk("R9 done after ack", {31'd0, done}, 32'd1);
      chk("R9 request dropped", {31'd0, mem_req}, 32'd0);
      chk("R9 cost", {28'd0, cycles}, 32'd4);
      chk("R11 no flags on transfer", {29'd0, trap_priv, bad_size, bad_ea}, 32'd0);
      chk("R9 write-back enable", {31'd0, rf_we}, {31'd0, !dir});
      if (!dir) begin
        exp_v = ref_load(model[sel], rdval, sz, sel[3]);
        chk("R4 write select", {28'd0, rf_wr_sel}, {28'd0, sel});
        chk(sel[3] ? "R7 address load" : "R6 data load", rf_wr_data, exp_v);
        model[sel] = exp_v;
      end
    end else begin
      chk("R1 done on fault", {31'd0, done}, 32'd1);
      chk("R1 privilege flag", {31'd0, trap_priv}, {31'd0, e_priv});
      chk("R1 vector", {24'd0, trap_vector}, e_priv ? 32'd8 : 32'd0);
      chk("R2 size flag", {31'd0, bad_size}, {31'd0, e_size});
      chk("R3 mode flag", {31'd0, bad_ea}, {31'd0, e_ea});
      chk("R3 no bus access", {31'd0, mem_req}, 32'd0);
      chk("R1 no write-back", {31'd0, rf_we}, 32'd0);
      chk("R9 zero cost on fault", {28'd0, cycles}, 32'd0);
    end
    if (poke) begin
      opcode = {8'h0E, 2'b10, 3'd2, 3'd0};
      ext_word = 16'h0000;
      supervisor = 1'b1;
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R10 idle after done", {29'd0, done, mem_req, busy}, 32'd0);
    chk("R8 register file", rf[sel], model[sel]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 32'h1357_9BDF ^ (i * 32'h0111_1111);
      model[i] = rf[i];
    end
    rst_n = 1'b0; start = 1'b0; opcode = '0; ext_word = '0; supervisor = 1'b0;
    ea_addr = '0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset idle", {29'd0, done, mem_req, busy}, 32'd0);
    rst_n = 1'b1;
    // loads into data registers
    run(2'b00, 3'd2, 3'd1, 4'd3,  1'b0, 1'b1, 32'h0000_1000, 32'h1234_56F7, 0, 1'b0);
    run(2'b01, 3'd5, 3'd4, 4'd5,  1'b0, 1'b1, 32'h0000_2002, 32'hAAAA_8123, 2, 1'b0);
    run(2'b10, 3'd7, 3'd1, 4'd0,  1'b0, 1'b1, 32'h00FF_0000, 32'hCAFE_F00D, 1, 1'b1);
    // loads into address registers
    run(2'b00, 3'd3, 3'd0, 4'd10, 1'b0, 1'b1, 32'h0000_0040, 32'h0000_0080, 0, 1'b0);
    run(2'b01, 3'd4, 3'd7, 4'd15, 1'b0, 1'b1, 32'h0000_3000, 32'hFFFF_7FFF, 3, 1'b0);
    run(2'b01, 3'd6, 3'd2, 4'd9,  1'b0, 1'b1, 32'h0000_3004, 32'h0000_8001, 1, 1'b0);
    run(2'b10, 3'd7, 3'd0, 4'd12, 1'b0, 1'b1, 32'h0000_0100, 32'h8765_4321, 0, 1'b0);
    // writes
    run(2'b00, 3'd2, 3'd3, 4'd1,  1'b1, 1'b1, 32'h0000_5000, 32'h0, 0, 1'b0);
    run(2'b01, 3'd5, 3'd5, 4'd12, 1'b1, 1'b1, 32'h0000_5002, 32'h0, 2, 1'b1);
    run(2'b10, 3'd6, 3'd6, 4'd6,  1'b1, 1'b1, 32'h0000_5004, 32'h0, 1, 1'b0);
    // faults
    run(2'b10, 3'd2, 3'd0, 4'd2,  1'b0, 1'b0, 32'h0000_6000, 32'h1111_1111, 0, 1'b1);
    run(2'b11, 3'd2, 3'd0, 4'd2,  1'b0, 1'b1, 32'h0000_6000, 32'h1111_1111, 0, 1'b0);
    run(2'b00, 3'd0, 3'd2, 4'd2,  1'b0, 1'b1, 32'h0000_6000, 32'h1111_1111, 0, 1'b0);
    run(2'b01, 3'd1, 3'd2, 4'd8,  1'b1, 1'b1, 32'h0000_6000, 32'h1111_1111, 0, 1'b0);
    run(2'b10, 3'd7, 3'd4, 4'd2,  1'b0, 1'b1, 32'h0000_6000, 32'h1111_1111, 0, 1'b0);
    // R11 priority collisions
    run(2'b11, 3'd0, 3'd0, 4'd2,  1'b0, 1'b0, 32'h0000_6000, 32'h1111_1111, 0, 1'b0);
    run(2'b11, 3'd1, 3'd0, 4'd2,  1'b1, 1'b1, 32'h0000_6000, 32'h1111_1111, 0, 1'b1);
    // a normal load after the faults
    run(2'b00, 3'd2, 3'd0, 4'd7,  1'b0, 1'b1, 32'h0000_7000, 32'h0000_0055, 0, 1'b0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule